// File: doc/BRIEF.md
# Receive Descriptor Writeback Engine

This block takes Ethernet frames arriving one byte per cycle and stores each one in host memory. The location comes from the receive descriptor that the current ring pointer selects. When a frame starts, the engine fetches that descriptor through a simple request/acknowledge memory port. It reads the ownership flag from the control word, the wrap flag from the size word and the buffer address. It then streams the frame bytes to the buffer one byte lane at a time. At the end of the frame it writes back a control word carrying the reported length and the completion status. It then advances the ring pointer, or wraps it back to the ring base.

Short frames (runts) and frames that arrive while the descriptor is still owned by the host are not delivered. Each outcome raises its own set of event pulses for the status register block next to this engine. Four saturating counters track accepted bytes, accepted frames, broadcast frames and multicast frames. A select input reads any one of them.

The controller has eight states. S_IDLE waits for a frame while reception is enabled. S_FETCH_CTL, S_FETCH_SIZE and S_FETCH_BUF read the three descriptor words. S_DATA accepts a byte. S_PUT writes that byte to memory. S_CLOSE classifies the outcome. S_WBACK writes the descriptor back.

The transitions are:
- S_IDLE→S_FETCH_CTL when reception is enabled and data is valid.
- S_FETCH_CTL→S_FETCH_SIZE when the descriptor is owned by the engine.
- S_FETCH_CTL→S_DATA when it is not owned, so the frame is drained.
- S_FETCH_SIZE→S_FETCH_BUF.
- S_FETCH_BUF→S_DATA.
- S_DATA→S_PUT when an owned byte is accepted.
- S_DATA→S_CLOSE on the last byte of a drained frame.
- S_PUT→S_DATA when more bytes follow.
- S_PUT→S_CLOSE after the last byte.
- S_CLOSE→S_IDLE for a runt or an unowned descriptor.
- S_CLOSE→S_WBACK otherwise.
- S_WBACK→S_IDLE on acknowledge.

Top module: `rx_desc_wb`

## Requirements
- R1: While the engine is idle and `rx_en` is low, `in_ready` stays low and no memory request is issued, even with `in_valid` high.
- R2: A frame of fewer than 12 bytes causes no descriptor writeback and leaves the pointer and the counters unchanged. It pulses `ev_ri` and `ev_nis` once. This outcome takes precedence over the ownership outcome.
- R3: If bit 31 of the descriptor control word (offset 0) is clear, the frame is still fully accepted but no memory write occurs. `ev_ru` and `ev_ais` pulse once, and the pointer and counters are unchanged.
- R4: For an owned descriptor, frame byte i is written to the buffer address read from descriptor offset 8, plus i. Each byte write enables exactly the byte lane given by address bits 1:0.
- R5: The writeback word at descriptor offset 0 holds (frame length + 4) in bits 30:16. Bit 31 is 0 and bits 15:0 equal 0x0300.
- R6: After a writeback, if bit 15 of the word at descriptor offset 4 was set, the pointer reloads the ring base. Otherwise it advances by 32.
- R7: A `base_wr` pulse loads both the ring base and the current pointer `desc_ptr` from `base_addr`.
- R8: A delivered frame whose destination is all ones counts as broadcast. One whose first byte has bit 0 set and that is not all ones counts as multicast. One whose first byte has bit 0 clear counts as neither.
- R9: Each delivered frame adds (length + 4) to the byte counter and 1 to the frame counter. All counters saturate at their maximum value and never wrap.
- R10: A delivered frame pulses `ev_ri` and `ev_nis` for exactly one cycle. `ev_ru` and `ev_ri` are never high together.
- R11: `cnt_sel` selects the counter on `cnt_data`: 0 bytes, 1 frames, 2 broadcast, 3 multicast.
- R12: Once raised, a memory request holds its address and direction stable until the cycle in which `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable from the control register |
| base_wr | input | 1 | Load pulse for the ring base |
| base_addr | input | AW | New ring base address |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Byte accepted when high with `in_valid` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | AW | Byte address of the access |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Completes the current request |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| desc_ptr | output | AW | Current descriptor address |
| ev_ri | output | 1 | Receive-complete event pulse |
| ev_nis | output | 1 | Normal-summary event pulse |
| ev_ru | output | 1 | Buffer-unavailable event pulse |
| ev_ais | output | 1 | Abnormal-summary event pulse |
| cnt_sel | input | 2 | Counter select |
| cnt_data | output | CNT_W | Selected counter value |

## Verification
The embedded properties check the following on every cycle:
- requests stay stable while they wait for acknowledge;
- no request starts while the engine is idle and disabled;
- every writeback word has its owner bit clear and the completion status in its low half;
- byte writes enable one lane only, and only for owned descriptors;
- the event pulses are exclusive and last one cycle;
- the pointer steps or reloads correctly;
- the counters never go backwards.

Only the bench scenarios can show the rest:
- that the stored bytes and the reported length match each frame;
- that the runt outcome wins over the unowned outcome;
- that the ring wraps at the flagged descriptor;
- that destination classes are counted correctly;
- that the byte counter saturates at the right total after a sweep of frame lengths.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH_CTL,
        S_FETCH_SIZE,
        S_FETCH_BUF,
        S_DATA,
        S_PUT,
        S_CLOSE,
        S_WBACK
    } rx_state_e;

    localparam int DESC_STRIDE = 32;
    localparam int OFS_SIZE    = 4;
    localparam int OFS_BUF     = 8;
    localparam int OWN_BIT     = 31;
    localparam int WRAP_BIT    = 15;
    localparam int CRC_PAD     = 4;
    localparam int MIN_FRAME   = 12;
    localparam int DA_BYTES    = 6;
    localparam logic [15:0] DONE_STATUS = 16'h0300;

    localparam int NUM_CNT    = 4;
    localparam int CNT_BYTES  = 0;
    localparam int CNT_FRAMES = 1;
    localparam int CNT_BCAST  = 2;
    localparam int CNT_MCAST  = 3;

endpackage

// File: rtl/rxwb_addr_class.sv
module rxwb_addr_class #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             take,
    input  logic [LEN_W-1:0] idx,
    input  logic [7:0]       data,
    output logic             is_bcast,
    output logic             is_mcast
);
    import rxwb_pkg::*;

    logic group_q;
    logic ones_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            group_q <= 1'b0;
            ones_q  <= 1'b1;
        end else if (clear) begin
            group_q <= 1'b0;
            ones_q  <= 1'b1;
        end else if (take && (idx < LEN_W'(DA_BYTES))) begin
            if (idx == '0) group_q <= data[0];
            ones_q <= ones_q && (data == 8'hFF);
        end
    end

    assign is_bcast = ones_q;
    assign is_mcast = group_q && !ones_q;

endmodule

// File: rtl/rxwb_ring_ptr.sv
module rxwb_ring_ptr #(
    parameter int AW   = 32,
    parameter int STEP = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_wr,
    input  logic [AW-1:0] base_data,
    input  logic          adv,
    input  logic          wrap,
    output logic [AW-1:0] ptr
);
    logic [AW-1:0] base_q;
    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            ptr_q  <= '0;
        end else if (base_wr) begin
            base_q <= base_data;
            ptr_q  <= base_data;
        end else if (adv) begin
            ptr_q <= wrap ? base_q : ptr_q + AW'(STEP);
        end
    end

    assign ptr = ptr_q;

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wrap && !base_wr) |=> (ptr == $past(ptr) + AW'(STEP))); // R6
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && wrap && !base_wr) |=> (ptr == $past(base_q))); // R6
    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |=> (ptr == $past(base_data))); // R7

endmodule

// File: rtl/rxwb_stat_cnt.sv
module rxwb_stat_cnt #(
    parameter int CNT_W = 64,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    input  logic [LEN_W:0]   add_bytes,
    input  logic             is_bcast,
    input  logic             is_mcast,
    input  logic [1:0]       sel,
    output logic [CNT_W-1:0] rdata
);
    import rxwb_pkg::*;

    localparam int SW = ((CNT_W > LEN_W + 1) ? CNT_W : LEN_W + 1) + 1;
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] cnt_q [NUM_CNT];
    logic [NUM_CNT-1:0] en_vec;

    always_comb begin
        en_vec = '0;
        en_vec[CNT_BYTES]  = bump;
        en_vec[CNT_FRAMES] = bump;
        en_vec[CNT_BCAST]  = bump && is_bcast;
        en_vec[CNT_MCAST]  = bump && is_mcast;
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        logic [SW-1:0] inc;
        logic [SW-1:0] sum;
        assign inc = (g == CNT_BYTES) ? SW'(add_bytes) : SW'(1);
        assign sum = SW'(cnt_q[g]) + inc;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else if (en_vec[g]) begin
                cnt_q[g] <= (sum > SW'(CMAX)) ? CMAX : sum[CNT_W-1:0];
            end
        end

        AST_CNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (cnt_q[g] >= $past(cnt_q[g]))); // R9
    end

    assign rdata = cnt_q[sel];

endmodule

// File: rtl/rx_desc_wb.sv
module rx_desc_wb #(
    parameter int AW    = 32,
    parameter int LEN_W = 16,
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             base_wr,
    input  logic [AW-1:0]    base_addr,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [3:0]       mem_be,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic [AW-1:0]    desc_ptr,
    output logic             ev_ri,
    output logic             ev_nis,
    output logic             ev_ru,
    output logic             ev_ais,
    input  logic [1:0]       cnt_sel,
    output logic [CNT_W-1:0] cnt_data
);
    import rxwb_pkg::*;

    rx_state_e        state_q, nxt;
    logic             owned_q, wrap_q, last_q;
    logic [AW-1:0]    buf_q;
    logic [LEN_W-1:0] len_q;
    logic [7:0]       byte_q;
    logic [LEN_W:0]   len4;
    logic [15:0]      len_field;
    logic [AW-1:0]    put_addr;
    logic             adv, bump, take;
    logic             is_bcast, is_mcast;

    assign len4      = {1'b0, len_q} + (LEN_W + 1)'(CRC_PAD);
    assign len_field = 16'(len4);
    assign put_addr  = buf_q + AW'(len_q) - AW'(1);
    assign take      = (state_q == S_DATA) && in_valid;

    rxwb_ring_ptr #(.AW(AW), .STEP(DESC_STRIDE)) u_ptr (
        .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_data(base_addr),
        .adv(adv), .wrap(wrap_q), .ptr(desc_ptr)
    );

    rxwb_addr_class #(.LEN_W(LEN_W)) u_class (
        .clk(clk), .rst_n(rst_n), .clear(state_q == S_IDLE), .take(take),
        .idx(len_q), .data(in_data), .is_bcast(is_bcast), .is_mcast(is_mcast)
    );

    rxwb_stat_cnt #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .bump(bump), .add_bytes(len4),
        .is_bcast(is_bcast), .is_mcast(is_mcast), .sel(cnt_sel), .rdata(cnt_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= nxt;
    end

    // frame context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owned_q <= 1'b0;
            wrap_q  <= 1'b0;
            last_q  <= 1'b0;
            buf_q   <= '0;
            len_q   <= '0;
            byte_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: len_q <= '0;
                S_FETCH_CTL: if (mem_ack) begin
                    owned_q <= mem_rdata[OWN_BIT];
                    wrap_q  <= 1'b0;
                end
                S_FETCH_SIZE: if (mem_ack) wrap_q <= mem_rdata[WRAP_BIT];
                S_FETCH_BUF:  if (mem_ack) buf_q  <= AW'(mem_rdata);
                S_DATA: if (in_valid) begin
                    byte_q <= in_data;
                    last_q <= in_last;
                    len_q  <= len_q + LEN_W'(1);
                end
                default: ;
            endcase
        end
    end

    // next state and outputs
    always_comb begin
        nxt       = state_q;
        in_ready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_ptr;
        mem_be    = 4'hF;
        mem_wdata = '0;
        ev_ri     = 1'b0;
        ev_nis    = 1'b0;
        ev_ru     = 1'b0;
        ev_ais    = 1'b0;
        adv       = 1'b0;
        bump      = 1'b0;
        unique case (state_q)
            S_IDLE: if (rx_en && in_valid) nxt = S_FETCH_CTL;
            S_FETCH_CTL: begin
                mem_req = 1'b1;
                if (mem_ack) nxt = mem_rdata[OWN_BIT] ? S_FETCH_SIZE : S_DATA;
            end
            S_FETCH_SIZE: begin
                mem_req  = 1'b1;
                mem_addr = desc_ptr + AW'(OFS_SIZE);
                if (mem_ack) nxt = S_FETCH_BUF;
            end
            S_FETCH_BUF: begin
                mem_req  = 1'b1;
                mem_addr = desc_ptr + AW'(OFS_BUF);
                if (mem_ack) nxt = S_DATA;
            end
            S_DATA: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    if (owned_q)      nxt = S_PUT;
                    else if (in_last) nxt = S_CLOSE;
                end
            end
            S_PUT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = put_addr;
                mem_be    = 4'b0001 << put_addr[1:0];
                mem_wdata = {4{byte_q}};
                if (mem_ack) nxt = last_q ? S_CLOSE : S_DATA;
            end
            S_CLOSE: begin
                if (len_q < LEN_W'(MIN_FRAME)) begin
                    ev_ri  = 1'b1;
                    ev_nis = 1'b1;
                    nxt    = S_IDLE;
                end else if (!owned_q) begin
                    ev_ru  = 1'b1;
                    ev_ais = 1'b1;
                    nxt    = S_IDLE;
                end else begin
                    nxt = S_WBACK;
                end
            end
            S_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {1'b0, len_field[14:0], DONE_STATUS};
                if (mem_ack) begin
                    adv    = 1'b1;
                    bump   = 1'b1;
                    ev_ri  = 1'b1;
                    ev_nis = 1'b1;
                    nxt    = S_IDLE;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R12
    AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !rx_en) |=> !mem_req); // R1
    AST_WB_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be == 4'hF) |-> (!mem_wdata[31] && mem_wdata[15:0] == 16'h0300)); // R5
    AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be != 4'hF) |-> ($countones(mem_be) == 1)); // R4
    AST_NO_WRITE_UNOWNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> owned_q); // R3
    AST_EV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ru |-> !ev_ri); // R10
    AST_EV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ri |=> !ev_ri); // R10

endmodule

// File: tb/rx_desc_wb_test.sv
module rx_desc_wb_test;

    localparam int AW = 32;
    localparam int LEN_W = 16;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0;
    logic base_wr = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic in_last = 1'b0;
    logic in_ready;
    logic mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [3:0] mem_be;
    logic [31:0] mem_wdata;
    logic mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [AW-1:0] desc_ptr;
    logic ev_ri, ev_nis, ev_ru, ev_ais;
    logic [1:0] cnt_sel = '0;
    logic [CNT_W-1:0] cnt_data;

    always #5 clk = ~clk;

    rx_desc_wb #(.AW(AW), .LEN_W(LEN_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .base_wr(base_wr), .base_addr(base_addr),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .desc_ptr(desc_ptr), .ev_ri(ev_ri), .ev_nis(ev_nis), .ev_ru(ev_ru), .ev_ais(ev_ais),
        .cnt_sel(cnt_sel), .cnt_data(cnt_data)
    );

    // memory model with host poke path
    logic [31:0] mem [0:255];
    logic host_we = 1'b0;
    logic [31:0] host_addr = '0;
    logic [31:0] host_data = '0;
    int wr_count = 0;
    int hold_err = 0;
    logic prev_pend = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    int n_ri = 0, n_nis = 0, n_ru = 0, n_ais = 0;

    always @(posedge clk) begin
        if (host_we) mem[host_addr[9:2]] <= host_data;
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            prev_pend <= 1'b0;
        end else begin
            if (mem_req && !mem_ack) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr[9:2]];
                if (mem_we) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
                    wr_count <= wr_count + 1;
                end
            end else begin
                mem_ack <= 1'b0;
            end
            if (prev_pend && (!mem_req || mem_addr != prev_addr)) hold_err <= hold_err + 1;
            prev_pend <= mem_req && !mem_ack;
            prev_addr <= mem_addr;
            n_ri  <= n_ri + int'(ev_ri);
            n_nis <= n_nis + int'(ev_nis);
            n_ru  <= n_ru + int'(ev_ru);
            n_ais <= n_ais + int'(ev_ais);
        end
    end

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_data = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic prep_desc(input logic [31:0] p, input bit own, input bit wrap, input logic [31:0] b);
        poke(p, own ? 32'h8000_0000 : 32'h0);
        poke(p + 4, wrap ? 32'h0000_8040 : 32'h0000_0040);
        poke(p + 8, b);
    endtask

    function automatic logic [7:0] fbyte(input int kind, input int i, input int len);
        if (i < 6) begin
            case (kind)
                0: return (i == 0) ? 8'h02 : 8'(8'h10 + i);
                1: return 8'hFF;
                2: return (i == 0) ? 8'h01 : 8'h00;
                default: return (i == 5) ? 8'hFE : 8'hFF;
            endcase
        end
        return 8'(len * 7 + i);
    endfunction

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        logic [31:0] w;
        w = mem[a[9:2]];
        return w[8*a[1:0] +: 8];
    endfunction

    task automatic send_frame(input int len, input int kind);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = fbyte(kind, i, len);
            in_last  = (i == len - 1);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic rd_cnt(input logic [1:0] s, output logic [63:0] v);
        @(negedge clk);
        cnt_sel = s;
        #1;
        v = 64'(cnt_data);
    endtask

    logic [31:0] base = 32'h0;
    logic [31:0] exp_ptr = 32'h0;
    int exp_bytes = 0, exp_frames = 0, exp_bc = 0, exp_mc = 0;

    function automatic int sat(input int v);
        return (v > 255) ? 255 : v;
    endfunction

    task automatic chk_counters(input string ctx);
        logic [63:0] v;
        rd_cnt(2'd0, v); chk({"R9 R11 byte counter ", ctx}, v, 64'(sat(exp_bytes)));
        rd_cnt(2'd1, v); chk({"R9 R11 frame counter ", ctx}, v, 64'(sat(exp_frames)));
        rd_cnt(2'd2, v); chk({"R8 R11 broadcast counter ", ctx}, v, 64'(sat(exp_bc)));
        rd_cnt(2'd3, v); chk({"R8 R11 multicast counter ", ctx}, v, 64'(sat(exp_mc)));
    endtask

    task automatic run_ok(input int len, input int kind);
        int k, bad, ri0, nis0, ru0;
        bit wrap;
        logic [31:0] bufa, dp;
        k    = int'((exp_ptr - base) / 32);
        wrap = (k == 3);
        bufa = 32'h201 + 32'(k) * 32'h40;
        dp   = exp_ptr;
        prep_desc(dp, 1'b1, wrap, bufa);
        ri0 = n_ri; nis0 = n_nis; ru0 = n_ru;
        send_frame(len, kind);
        chk("R5 writeback word", 64'(mem[dp[9:2]]), 64'((32'(len + 4) << 16) | 32'h300));
        bad = 0;
        for (int i = 0; i < len; i++) if (mbyte(bufa + 32'(i)) !== fbyte(kind, i, len)) bad++;
        chk("R4 buffer bytes mismatched", 64'(bad), 64'd0);
        exp_ptr = wrap ? base : exp_ptr + 32;
        chk("R6 pointer after writeback", 64'(desc_ptr), 64'(exp_ptr));
        chk("R10 ri/nis pulses", 64'({n_ri - ri0, n_nis - nis0}), 64'({32'd1, 32'd1}));
        chk("R10 no ru pulse", 64'(n_ru - ru0), 64'd0);
        exp_bytes += len + 4;
        exp_frames++;
        if (kind == 1) exp_bc++;
        if (kind == 2 || kind == 3) exp_mc++;
        chk_counters("after delivery");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int bad, ri0, ru0, ais0, w0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset in_ready", 64'(in_ready), 64'd0);
        chk("R12 reset mem_req", 64'(mem_req), 64'd0);
        chk("R7 reset desc_ptr", 64'(desc_ptr), 64'd0);
        chk_counters("at reset");

        // R1: gate closed
        bad = 0;
        in_valid = 1'b1; in_data = 8'h55;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (in_ready || mem_req) bad++;
        end
        in_valid = 1'b0;
        chk("R1 activity while disabled", 64'(bad), 64'd0);
        rx_en = 1'b1;

        // delivery sweep over lengths and destination classes
        for (int len = 12; len <= 44; len++) run_ok(len, len % 4);

        // R2: runts, owned descriptor
        for (int len = 1; len <= 11; len++) begin
            prep_desc(exp_ptr, 1'b1, 1'b0, 32'h2F0);
            ri0 = n_ri; ru0 = n_ru;
            send_frame(len, 0);
            chk("R2 runt ri pulse", 64'(n_ri - ri0), 64'd1);
            chk("R2 runt no ru pulse", 64'(n_ru - ru0), 64'd0);
            chk("R2 runt pointer unchanged", 64'(desc_ptr), 64'(exp_ptr));
            chk("R2 runt descriptor not written back", 64'(mem[exp_ptr[9:2]]), 64'h8000_0000);
        end
        chk_counters("after runts R2");

        // R3: unowned descriptor
        prep_desc(exp_ptr, 1'b0, 1'b0, 32'h2F0);
        ri0 = n_ri; ru0 = n_ru; ais0 = n_ais; w0 = wr_count;
        send_frame(16, 0);
        chk("R3 no memory writes", 64'(wr_count - w0), 64'd0);
        chk("R3 ru/ais pulses", 64'({n_ru - ru0, n_ais - ais0}), 64'({32'd1, 32'd1}));
        chk("R3 no ri pulse", 64'(n_ri - ri0), 64'd0);
        chk("R3 pointer unchanged", 64'(desc_ptr), 64'(exp_ptr));
        chk_counters("after unowned R3");

        // R2 precedence: unowned runt
        ri0 = n_ri; ru0 = n_ru;
        send_frame(5, 1);
        chk("R2 unowned runt reports ri", 64'(n_ri - ri0), 64'd1);
        chk("R2 unowned runt no ru", 64'(n_ru - ru0), 64'd0);

        // R7: base reload, then ring wrap around the new base
        @(negedge clk);
        base_wr = 1'b1; base_addr = 32'h40;
        @(negedge clk);
        base_wr = 1'b0;
        base = 32'h40; exp_ptr = 32'h40;
        chk("R7 pointer after base load", 64'(desc_ptr), 64'h40);
        for (int n = 0; n < 5; n++) run_ok(20 + n, n % 4);

        chk("R12 request hold violations", 64'(hold_err), 64'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule